// File: doc/BRIEF.md
# DDR Midpoint Interpolator with Sinusoid Gain Correction

This block doubles the sample rate of a signed data stream so that a DAC clocked at twice the fabric rate can be fed in DDR fashion. On every clock it accepts one signed sample and presents two DAC words. The first word of the pair is a stored input sample, reduced to the DAC width. The second word is an estimate of the signal halfway between that sample and the next one.

Averaging two neighbouring samples of a sinusoid gives a value that is too small by the cosine of half the phase step between them. The sum is therefore multiplied by a runtime coefficient, which software computes as ceil(32768 · 0.5 · sec(π·f)), where f is the intermediate frequency as a fraction of the clock. With that coefficient, a tone at the chosen frequency is interpolated with no amplitude loss. For example, f = 16/101 gives 18646. A coefficient of 16384 gives a plain average. Both words are produced in offset binary, which the DAC expects.

The input is 17 bits wide. A 16-bit source is applied with a zero appended as its least significant bit. The midpoint path rounds its result and saturates it to the DAC width, so a large coefficient cannot wrap the output.

Top module: `ddr_midpoint_interp`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after it is released, both output words read 0x8000.
- R2: After a rising edge, word_even_o holds the sample applied three edges earlier, arithmetically shifted right by one bit (floor) and converted to offset binary.
- R3: After a rising edge, word_odd_o holds the midpoint of that same sample and the one applied two edges earlier. The midpoint is (a + b) · coeff_in, plus 2^15, arithmetically shifted right by 16, saturated to 16-bit signed, then converted to offset binary.
- R4: When the scaled midpoint exceeds the 16-bit signed range, it saturates. Offset binary 0xFFFF marks the positive limit and 0x0000 the negative limit.
- R5: Offset binary is the two's-complement word with its MSB inverted, so a run of zero samples gives 0x8000 on both words.
- R6: A coefficient of 16384 yields the plain average. Two equal samples whose least significant bit is zero give word_odd_o equal to word_even_o.
- R7: For a cosine of amplitude 30000 (16-bit units) at f = 16/101 with coeff_in = 18646, every midpoint word lies within 2 LSB of the true cosine value halfway between samples.
- R8: A change on coeff_in takes effect on the midpoint from the first rising edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 17 | Signed input sample (16-bit source with a zero LSB appended) |
| coeff_in | input | 16 | Unsigned midpoint gain, 1.0 = 32768 |
| word_even_o | output | 16 | Offset-binary direct sample, first half of the DAC period |
| word_odd_o | output | 16 | Offset-binary corrected midpoint, second half of the DAC period |

## Verification
A zero stream pins down the offset-binary zero code. An evenly spaced ramp under the unity-average coefficient separates a correct pairing of samples from one that is off by a clock. Pseudo-random samples that include odd values exercise the floor on the direct path and the round-half-up on the midpoint, at a non-trivial coefficient. Full-scale runs with the maximum coefficient show whether the result saturates or wraps. A coefficient step on a flat input exposes the latency of the gain. A sampled cosine at 16/101 with the secant coefficient is compared with the ideal sinusoid, which confirms that the correction restores the amplitude that plain averaging loses.

// File: rtl/dmi_pkg.sv
package dmi_pkg;

   // Binary point of the gain word: 1.0 is 2**DMI_COEF_FRAC.
   localparam int DMI_COEF_FRAC = 15;

   // Sum of two samples needs one growth bit.
   function automatic int sum_width(input int data_w);
      return data_w + 1;
   endfunction

   // Signed sum times zero-extended unsigned gain.
   function automatic int prod_width(input int data_w, input int coef_w);
      return sum_width(data_w) + coef_w + 1;
   endfunction

   // Output lanes in DDR order.
   typedef enum logic [0:0] {
      LANE_DIRECT = 1'b0,
      LANE_MID    = 1'b1
   } lane_e;

   localparam int DMI_LANES = 2;

endpackage

// File: rtl/dmi_sample_pipe.sv
module dmi_sample_pipe #(
   parameter int DATA_W = 17
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] sample_i,
   output logic signed [DATA_W-1:0] newer_o,
   output logic signed [DATA_W-1:0] older_o
);

   initial begin
      assert (DATA_W >= 2)
         else $error("dmi_sample_pipe: DATA_W must be at least 2");
   end

   // Two-deep history: newer_o is x[n+1], older_o is x[n].
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         newer_o <= '0;
         older_o <= '0;
      end else begin
         newer_o <= sample_i;
         older_o <= newer_o;
      end
   end

endmodule

// File: rtl/dmi_midpoint.sv
module dmi_midpoint #(
   parameter int DATA_W    = 17,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 15,
   parameter int OUT_W     = 16
) (
   input  logic signed [DATA_W-1:0] older_i,
   input  logic signed [DATA_W-1:0] newer_i,
   input  logic        [COEF_W-1:0] coeff_i,
   output logic signed [OUT_W-1:0]  mid_o
);

   localparam int SUM_W  = dmi_pkg::sum_width(DATA_W);
   localparam int PROD_W = dmi_pkg::prod_width(DATA_W, COEF_W);
   // Gain binary point plus the bits dropped going to the DAC width.
   localparam int SHIFT  = COEF_FRAC + DATA_W - OUT_W;
   localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) << (SHIFT - 1);
   localparam logic signed [PROD_W-1:0] MAX_V =
      {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] MIN_V =
      {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   initial begin
      assert (SHIFT >= 1)
         else $error("dmi_midpoint: COEF_FRAC + DATA_W - OUT_W must be positive");
      assert (PROD_W > OUT_W)
         else $error("dmi_midpoint: product narrower than output");
   end

   logic signed [SUM_W-1:0]  pair_sum;
   logic signed [COEF_W:0]   gain_s;
   logic signed [PROD_W-1:0] product;
   logic signed [PROD_W-1:0] biased;
   logic signed [PROD_W-1:0] scaled;

   assign pair_sum = SUM_W'(older_i) + SUM_W'(newer_i);
   assign gain_s   = $signed({1'b0, coeff_i});
   assign product  = PROD_W'(pair_sum) * PROD_W'(gain_s);
   assign biased   = product + HALF;      // round half up
   assign scaled   = biased >>> SHIFT;

   // Saturation is only built when the gain can exceed the output range.
   if (COEF_W + 2 > COEF_FRAC) begin : g_sat
      always_comb begin
         if (scaled > MAX_V) begin
            mid_o = MAX_V[OUT_W-1:0];
         end else if (scaled < MIN_V) begin
            mid_o = MIN_V[OUT_W-1:0];
         end else begin
            mid_o = scaled[OUT_W-1:0];
         end
      end
   end else begin : g_nosat
      assign mid_o = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/dmi_word_fmt.sv
module dmi_word_fmt #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] value_i,
   output logic        [W-1:0] word_o
);

   initial begin
      assert (W >= 2) else $error("dmi_word_fmt: W must be at least 2");
   end

   logic signed [W-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
      end else begin
         held <= value_i;
      end
   end

   // Two's complement to offset binary: flip the sign bit.
   assign word_o = {~held[W-1], held[W-2:0]};

endmodule

// File: rtl/ddr_midpoint_interp.sv
module ddr_midpoint_interp
   import dmi_pkg::*;
#(
   parameter int DATA_W    = 17,
   parameter int OUT_W     = 16,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = DMI_COEF_FRAC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] sample_in,
   input  logic        [COEF_W-1:0] coeff_in,
   output logic        [OUT_W-1:0]  word_even_o,
   output logic        [OUT_W-1:0]  word_odd_o
);

   localparam int DROP = DATA_W - OUT_W;

   initial begin
      assert (DROP >= 0)
         else $error("ddr_midpoint_interp: OUT_W wider than DATA_W");
      assert (COEF_FRAC >= 1 && COEF_FRAC < COEF_W + 2)
         else $error("ddr_midpoint_interp: COEF_FRAC out of range");
   end

   logic signed [DATA_W-1:0] newer_s;
   logic signed [DATA_W-1:0] older_s;
   logic signed [OUT_W-1:0]  direct_s;
   logic signed [OUT_W-1:0]  mid_s;
   logic signed [OUT_W-1:0]  lane_val  [DMI_LANES];
   logic        [OUT_W-1:0]  lane_word [DMI_LANES];

   dmi_sample_pipe #(
      .DATA_W (DATA_W)
   ) pipe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (sample_in),
      .newer_o  (newer_s),
      .older_o  (older_s)
   );

   // Direct lane: keep the top OUT_W bits (floor).
   if (DROP > 0) begin : g_trim
      assign direct_s = older_s[DATA_W-1 -: OUT_W];
   end else begin : g_pass
      assign direct_s = older_s;
   end

   dmi_midpoint #(
      .DATA_W    (DATA_W),
      .COEF_W    (COEF_W),
      .COEF_FRAC (COEF_FRAC),
      .OUT_W     (OUT_W)
   ) mid_i (
      .older_i (older_s),
      .newer_i (newer_s),
      .coeff_i (coeff_in),
      .mid_o   (mid_s)
   );

   assign lane_val[int'(LANE_DIRECT)] = direct_s;
   assign lane_val[int'(LANE_MID)]    = mid_s;

   for (genvar ln = 0; ln < DMI_LANES; ln++) begin : g_lane
      dmi_word_fmt #(
         .W (OUT_W)
      ) fmt_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .value_i (lane_val[ln]),
         .word_o  (lane_word[ln])
      );
   end

   assign word_even_o = lane_word[int'(LANE_DIRECT)];
   assign word_odd_o  = lane_word[int'(LANE_MID)];

endmodule

// File: rtl/ddr_midpoint_interp_chk.sv
module ddr_midpoint_interp_chk #(
   parameter int DATA_W    = 17,
   parameter int OUT_W     = 16,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 15
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic signed [DATA_W-1:0] sample_in,
   input logic        [COEF_W-1:0] coeff_in,
   input logic        [OUT_W-1:0]  word_even_o,
   input logic        [OUT_W-1:0]  word_odd_o
);

   localparam logic [OUT_W-1:0]  ZERO_WORD = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0]  TOP_WORD  = {OUT_W{1'b1}};
   localparam logic [OUT_W-1:0]  BOT_WORD  = {OUT_W{1'b0}};
   localparam logic [COEF_W-1:0] UNITY_AVG = COEF_W'(1) << (COEF_FRAC - 1);
   localparam logic [COEF_W-1:0] GAIN_MAX  = {COEF_W{1'b1}};
   localparam logic signed [DATA_W-1:0] IN_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] IN_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   // Edges since reset release, saturating; history is valid from 3 on.
   logic [2:0] run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (run_cnt != 3'd7) begin
         run_cnt <= run_cnt + 3'd1;
      end
   end

   // R1: reset values persist for two edges after release
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt <= 3'd1) |-> (word_even_o == ZERO_WORD && word_odd_o == ZERO_WORD));

   // R2: direct word is the sample three edges back, top bits, offset binary
   p_direct_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= 3'd3) |->
      (word_even_o == ($past(sample_in[DATA_W-1 -: OUT_W], 3) ^ ZERO_WORD)));

   // R5: zero history gives the offset-binary zero code on both words
   p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= 3'd3 && $past(sample_in, 2) == '0 && $past(sample_in, 3) == '0) |->
      (word_odd_o == ZERO_WORD && word_even_o == ZERO_WORD));

   // R6: unity-average gain on equal even samples reproduces the sample
   p_unity_avg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= 3'd3 && $past(coeff_in) == UNITY_AVG &&
       $past(sample_in, 2) == $past(sample_in, 3) && !$past(sample_in[0], 2)) |->
      (word_odd_o == word_even_o));

   // R4: positive full scale at maximum gain clips high
   p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= 3'd3 && $past(coeff_in) == GAIN_MAX &&
       $past(sample_in, 2) == IN_MAX && $past(sample_in, 3) == IN_MAX) |->
      (word_odd_o == TOP_WORD));

   // R4: negative full scale at maximum gain clips low
   p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt >= 3'd3 && $past(coeff_in) == GAIN_MAX &&
       $past(sample_in, 2) == IN_MIN && $past(sample_in, 3) == IN_MIN) |->
      (word_odd_o == BOT_WORD));

endmodule

bind ddr_midpoint_interp ddr_midpoint_interp_chk #(
   .DATA_W    (DATA_W),
   .OUT_W     (OUT_W),
   .COEF_W    (COEF_W),
   .COEF_FRAC (COEF_FRAC)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_in   (sample_in),
   .coeff_in    (coeff_in),
   .word_even_o (word_even_o),
   .word_odd_o  (word_odd_o)
);

// File: tb/ddr_midpoint_interp_tb_top.sv
`timescale 1ns / 1ps
module ddr_midpoint_interp_tb_top;

   localparam real PI   = 3.14159265358979323846;
   localparam real FREQ = 16.0 / 101.0;
   localparam real AMP  = 30000.0;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [16:0] sample_in = '0;
   logic        [15:0] coeff_in = 16'd16384;
   logic        [15:0] word_even_o;
   logic        [15:0] word_odd_o;

   always #10 clk = ~clk;   // 50 MHz

   ddr_midpoint_interp dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_in   (sample_in),
      .coeff_in    (coeff_in),
      .word_even_o (word_even_o),
      .word_odd_o  (word_odd_o)
   );

   typedef struct {
      int    older;
      int    newer;
      int    due;
      string tag;
      bit    cos_chk;
      real   truth;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   int          prev = 0;
   logic [15:0] coeff_seen = '0;
   logic [31:0] seed = 32'h1234_5678;

   // Edge count and the gain the design sampled at each edge.
   always @(posedge clk) begin
      cyc        <= cyc + 1;
      coeff_seen <= coeff_in;
   end

   function automatic int mid_ref(input int a, input int b, input int c);
      longint p;
      p = longint'(a + b) * longint'(c);
      p = (p + 64'sd32768) >>> 16;
      if (p > 32767)  p = 32767;
      if (p < -32768) p = -32768;
      return int'(p);
   endfunction

   function automatic logic [15:0] ob(input int v);
      return 16'(v + 32768);
   endfunction

   task automatic check16(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor: items fall due two edges after their sample is applied.
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
         item_t it;
         int    got;
         real   err;
         it = sb_q.pop_front();
         check16("R2", "direct word", word_even_o, ob(it.older >>> 1));
         check16(it.tag, "midpoint word", word_odd_o,
                 ob(mid_ref(it.older, it.newer, int'(coeff_seen))));
         if (it.cos_chk) begin
            got = int'($signed(word_odd_o ^ 16'h8000));
            err = real'(got) - it.truth;
            n_checks++;
            if (err > 2.0 || err < -2.0) begin
               n_fail++;
               $display("FAIL R7 cosine midpoint: actual %0d expected %0.2f", got, it.truth);
            end
         end
      end
   end

   task automatic drive(input int x, input string tag,
                        input bit cchk = 1'b0, input real truth = 0.0);
      item_t it;
      @(negedge clk);
      sample_in  = 17'(x);
      it.older   = prev;
      it.newer   = x;
      it.due     = cyc + 2;
      it.tag     = tag;
      it.cos_chk = cchk;
      it.truth   = truth;
      sb_q.push_back(it);
      prev = x;
   endtask

   function automatic int next_rand();
      int v;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = int'((seed >> 9) & 32'h1FFFF);
      if (v >= 65536) v = v - 131072;
      return v;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check16("R1", "even during reset", word_even_o, 16'h8000);
      check16("R1", "odd during reset", word_odd_o, 16'h8000);
      rst_n = 1'b1;
      repeat (2) begin
         @(negedge clk);
         check16("R1", "even after release", word_even_o, 16'h8000);
         check16("R1", "odd after release", word_odd_o, 16'h8000);
      end

      // R5: zero stream
      coeff_in = 16'd16384;
      repeat (4) drive(0, "R5");

      // R6: even ramp under the plain-average gain
      for (int k = 0; k < 10; k++) drive(k * 2000 - 9000, "R6");
      repeat (3) drive(4000, "R6");

      // R3: pseudo-random samples, odd values included, secant gain
      coeff_in = 16'd18646;
      for (int k = 0; k < 24; k++) drive(next_rand(), "R3");
      coeff_in = 16'd0;
      repeat (3) drive(next_rand(), "R3");

      // R4: clipping at both ends with maximum gain
      coeff_in = 16'hFFFF;
      repeat (3) drive(65535, "R4");
      repeat (3) drive(-65536, "R4");
      repeat (2) drive(40000, "R4");

      // R8: gain step on a flat input
      coeff_in = 16'd16384;
      repeat (4) drive(20000, "R8");
      coeff_in = 16'd32768;
      repeat (2) drive(20000, "R8");
      coeff_in = 16'd24576;
      repeat (2) drive(20000, "R8");

      // R7: cosine at 16/101 with the secant-corrected gain
      coeff_in = 16'd18646;
      for (int k = 0; k < 202; k++) begin
         int  s16;
         real tv;
         s16 = int'(AMP * $cos(2.0 * PI * FREQ * real'(k)));
         tv  = AMP * $cos(2.0 * PI * FREQ * (real'(k) - 0.5));
         drive(2 * s16, "R7", k >= 1, tv);
      end

      repeat (4) drive(0, "R5");
      while (sb_q.size() > 0) @(negedge clk);

      // R1: a second reset clears the pipeline even with a live input
      rst_n     = 1'b0;
      sample_in = 17'sd12345;
      repeat (2) @(negedge clk);
      check16("R1", "even in second reset", word_even_o, 16'h8000);
      check16("R1", "odd in second reset", word_odd_o, 16'h8000);

      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule